// File: doc/BRIEF.md
# Store Data Forwarding Select

This block is a purely combinational selector used in a five-stage in-order pipeline. When the instruction now in the execute stage writes memory, the value it stores may still be travelling down the pipeline. In that case it is not yet in the register file. The selector compares the store's data source register with the destinations of the two in-flight producers. It then emits a two-bit code that drives the store-data multiplexer outside the block.

The two producers are the instruction in the execute/memory latch (the newer one) and the instruction in the memory/writeback latch (the older one). The older producer may be an arithmetic result or a load that has reached writeback. When both producers could supply the value, the newer one wins. Register zero is hard-wired and never forwards.

Top module: `store_fwd_sel`

## Requirements
- R1: While `ex_is_store` is 0, `fwd_sel` is 2'b00 (register-file value), whatever the other inputs are.
- R2: With a store in execute, `fwd_sel` is 2'b10 when `exm_wr_en` is 1, `exm_dst` equals `ex_data_reg` and `exm_dst` is not 0.
- R3: With a store in execute, `fwd_sel` is 2'b01 when `mwb_wr_en` is 1, `mwb_dst` equals `ex_data_reg`, `mwb_dst` is not 0, and `exm_dst` differs from `ex_data_reg`.
- R4: When both latches qualify for forwarding, `fwd_sel` is 2'b10, so the newer result takes priority.
- R5: A destination of register 0 never forwards, even when its write enable is 1.
- R6: A latch whose write enable is 0 never forwards, even when its destination matches.
- R7: A register-number match between `exm_dst` and `ex_data_reg` blocks the memory/writeback path on its own. This holds even when `exm_wr_en` is 0, and then `fwd_sel` is 2'b00.
- R8: The code 2'b11 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_is_store | input | 1 | Memory-write control of the execute-stage instruction |
| ex_data_reg | input | REG_W | Register whose value the store writes to memory |
| exm_wr_en | input | 1 | Register-write enable held in the execute/memory latch |
| exm_dst | input | REG_W | Destination register held in the execute/memory latch |
| mwb_wr_en | input | 1 | Register-write enable held in the memory/writeback latch |
| mwb_dst | input | REG_W | Destination register held in the memory/writeback latch |
| fwd_sel | output | 2 | 00 register file, 10 execute/memory result, 01 memory/writeback result |

## Verification
The bench builds the block with a 3-bit register number instead of the default 5. This shrinks the input space to 4096 combinations, and every one is applied. The zero-register guard, the priority of the newer latch and the equality-only blocking of the older path are therefore each reached with every register value. The expected code is computed in the bench from the rules above.

// File: rtl/store_fwd_pkg.sv
package store_fwd_pkg;
   typedef enum logic [1:0] {
      SRC_REGFILE = 2'b00,
      SRC_OLDER   = 2'b01,
      SRC_NEWER   = 2'b10
   } data_src_e;
endpackage

// File: rtl/store_fwd_hit.sv
module store_fwd_hit #(
   parameter int REG_W     = 5,
   parameter bit SKIP_ZERO = 1'b1
) (
   input  logic             wr_en,
   input  logic [REG_W-1:0] dst,
   input  logic [REG_W-1:0] src,
   output logic             same_reg,
   output logic             hit
);
   localparam logic [REG_W-1:0] ZERO_REG = '0;

   if (REG_W < 1) begin : g_bad_width
      $error("store_fwd_hit: REG_W must be at least 1");
   end

   assign same_reg = (dst == src);

   if (SKIP_ZERO) begin : g_zero_guard
      assign hit = wr_en && same_reg && (dst != ZERO_REG);
   end else begin : g_no_guard
      assign hit = wr_en && same_reg;
   end

   always_comb begin
      // R6: no write enable, no hit
      a_r6_no_hit_without_write: assert (wr_en || !hit);
      // R5: register zero never produces a hit
      if (SKIP_ZERO) a_r5_zero_never_hits: assert (!(hit && dst == ZERO_REG));
   end
endmodule

// File: rtl/store_fwd_prio.sv
module store_fwd_prio
   import store_fwd_pkg::*;
(
   input  logic      is_store,
   input  logic      newer_hit,
   input  logic      newer_same,
   input  logic      older_hit,
   output data_src_e sel
);
   always_comb begin
      sel = SRC_REGFILE;
      if (is_store) begin
         if (newer_hit)                     sel = SRC_NEWER;
         else if (older_hit && !newer_same) sel = SRC_OLDER;
      end
   end

   always_comb begin
      // R4: newer producer wins when both qualify
      a_r4_newer_priority: assert (!(is_store && newer_hit && older_hit) || sel == SRC_NEWER);
      // R7: equal newer destination blocks the older path
      a_r7_equality_blocks_older: assert (!newer_same || sel != SRC_OLDER);
   end
endmodule

// File: rtl/store_fwd_sel.sv
module store_fwd_sel
   import store_fwd_pkg::*;
#(
   parameter int REG_W     = 5,
   parameter bit SKIP_ZERO = 1'b1
) (
   input  logic             ex_is_store,
   input  logic [REG_W-1:0] ex_data_reg,
   input  logic             exm_wr_en,
   input  logic [REG_W-1:0] exm_dst,
   input  logic             mwb_wr_en,
   input  logic [REG_W-1:0] mwb_dst,
   output logic [1:0]       fwd_sel
);
   localparam int N_LATCH = 2;

   if (REG_W < 1 || REG_W > 8) begin : g_bad_cfg
      $error("store_fwd_sel: REG_W out of supported range 1..8");
   end

   logic [N_LATCH-1:0]             lat_we;
   logic [N_LATCH-1:0][REG_W-1:0]  lat_dst;
   logic [N_LATCH-1:0]             lat_same;
   logic [N_LATCH-1:0]             lat_hit;
   data_src_e                      sel_e;

   // index 0: newer (execute/memory), index 1: older (memory/writeback)
   assign lat_we  = {mwb_wr_en, exm_wr_en};
   assign lat_dst = {mwb_dst, exm_dst};

   for (genvar i = 0; i < N_LATCH; i++) begin : g_latch
      store_fwd_hit #(.REG_W(REG_W), .SKIP_ZERO(SKIP_ZERO)) u_hit (
         .wr_en    (lat_we[i]),
         .dst      (lat_dst[i]),
         .src      (ex_data_reg),
         .same_reg (lat_same[i]),
         .hit      (lat_hit[i])
      );
   end

   store_fwd_prio u_prio (
      .is_store   (ex_is_store),
      .newer_hit  (lat_hit[0]),
      .newer_same (lat_same[0]),
      .older_hit  (lat_hit[1]),
      .sel        (sel_e)
   );

   assign fwd_sel = sel_e;

   always_comb begin
      // R1: not a store, register file value
      a_r1_idle_without_store: assert (ex_is_store || fwd_sel == 2'b00);
      // R8: reserved code never appears
      a_r8_no_reserved_code: assert (fwd_sel != 2'b11);
      // R2: a newer match with a nonzero destination forwards the newer value
      a_r2_newer_forward: assert (!(ex_is_store && exm_wr_en && exm_dst == ex_data_reg
                                    && exm_dst != '0) || fwd_sel == 2'b10);
   end
endmodule

// File: tb/store_fwd_sel_test.sv
module store_fwd_sel_test;
   localparam int W = 3;
   localparam int N = 1 << W;

   logic         clk = 1'b0;
   logic         st = 1'b0;
   logic [W-1:0] src = '0;
   logic         xwe = 1'b0;
   logic [W-1:0] xdst = '0;
   logic         mwe = 1'b0;
   logic [W-1:0] mdst = '0;
   logic [1:0]   sel;
   int           n_checks = 0;
   int           n_fail = 0;
   bit           done = 1'b0;

   always #10 clk = ~clk;

   store_fwd_sel #(.REG_W(W)) uut (
      .ex_is_store (st),
      .ex_data_reg (src),
      .exm_wr_en   (xwe),
      .exm_dst     (xdst),
      .mwb_wr_en   (mwe),
      .mwb_dst     (mdst),
      .fwd_sel     (sel)
   );

   task automatic check(input logic [1:0] exp, input string tag);
      n_checks++;
      if (sel !== exp) begin
         n_fail++;
         $display("FAIL %s: st=%0b src=%0d xwe=%0b xdst=%0d mwe=%0b mdst=%0d actual=%b expected=%b",
                  tag, st, src, xwe, xdst, mwe, mdst, sel, exp);
      end
   endtask

   initial begin
      @(negedge clk);
      #5 check(2'b00, "R1 reset-like idle");
      for (int a = 0; a < 2; a++)
         for (int s = 0; s < N; s++)
            for (int xw = 0; xw < 2; xw++)
               for (int xd = 0; xd < N; xd++)
                  for (int mw = 0; mw < 2; mw++)
                     for (int md = 0; md < N; md++) begin
                        logic [1:0] e;
                        string tg;
                        bit nh, oh;
                        @(negedge clk);
                        st = a[0]; src = W'(s); xwe = xw[0]; xdst = W'(xd);
                        mwe = mw[0]; mdst = W'(md);
                        nh = xw == 1 && xd == s && xd != 0;
                        oh = mw == 1 && md == s && md != 0;
                        if (a == 0) begin e = 2'b00; tg = "R1"; end
                        else if (nh) begin e = 2'b10; tg = oh ? "R4" : "R2"; end
                        else if (xd == s && oh) begin e = 2'b00; tg = "R7"; end
                        else if (oh) begin e = 2'b01; tg = "R3"; end
                        else begin
                           e = 2'b00;
                           if ((xw == 1 && xd == 0 && s == 0) || (mw == 1 && md == 0 && s == 0)) tg = "R5";
                           else tg = "R6";
                        end
                        #5;
                        check(e, tg);
                        n_checks++;
                        if (sel === 2'b11) begin
                           n_fail++;
                           $display("FAIL R8: actual=%b expected=not 11", sel);
                        end
                     end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule